// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Set-Less-Than

This block is the integer arithmetic and logic unit of a small RISC datapath. It takes two operands and a 4-bit operation code. In the same cycle it returns a result word, a flag that is high when that result is all zeros, and a signed-overflow flag. It has no clock and no state. The outputs follow the inputs through gates alone, so the block sits between the register-read and write-back stages of the surrounding pipeline.

The word is built from identical one-bit slices joined by a ripple carry chain. Each slice can invert its A input and its B input, and it holds an AND gate, an OR gate, a full adder and a four-way output selector. The operation code is read as four control fields:

- bit 3 inverts A.
- bit 2 inverts B and also feeds a carry of 1 into bit 0.
- bits 1:0 select the slice output: 00 AND, 01 OR, 10 sum, 11 less-than.

With these fields, subtraction reuses the adder and NOR reuses the AND gate. The top slice has its own form. It exports its adder sum and its overflow. The sign of the difference, corrected by the overflow, is routed back as the less-than bit of slice 0.

Top module: `bitslice_alu`

## Requirements
- R1: Code 0000 gives the bitwise AND of A and B, and code 0001 gives the bitwise OR.
- R2: Code 0010 gives A plus B modulo 2^WIDTH.
- R3: Code 0110 gives A minus B modulo 2^WIDTH. It is computed as A plus inverted B with a carry-in of 1.
- R4: Code 0111 puts 1 in result bit 0 when A is less than B as signed two's-complement numbers, and 0 otherwise. Result bits WIDTH-1 down to 1 are zero. The comparison stays correct when A minus B overflows.
- R5: Code 1100 gives the bitwise NOR of A and B.
- R6: The zero output is 1 exactly when every result bit is 0, for every operation code.
- R7: The overflow output is 1 for codes 0010 and 0110 exactly when the signed result does not fit in WIDTH bits. It is 0 for every other code.
- R8: The codes not named in R1 to R5 give a result of all zeros. For these codes the zero output is 1 and the overflow output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 4 | Operation code: bit 3 inverts A, bit 2 negates B, bits 1:0 select the output |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds one instance with WIDTH = 5. At that width all sixteen operation codes can be swept against every pair of operands, which is 16,384 cases. The sweep covers every sign combination, every overflow in both directions, every less-than decision on an overflowing difference, and every unused code. A second instance with the default WIDTH = 32 takes directed corner operands: the extreme signed values, equal operands, and carry chains that ripple across the full word. These confirm that the same slices and control fields scale to the full word.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic     inv_a;
        logic     neg_b;
        alu_sel_e sel;
    } alu_ctrl_t;

    localparam logic [3:0] OP_AND = 4'b0000;
    localparam logic [3:0] OP_OR  = 4'b0001;
    localparam logic [3:0] OP_ADD = 4'b0010;
    localparam logic [3:0] OP_SUB = 4'b0110;
    localparam logic [3:0] OP_SLT = 4'b0111;
    localparam logic [3:0] OP_NOR = 4'b1100;

    // Full adder on the conditioned operands; returns {carry_out, sum}.
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic cin);
        return {(x & y) | (x & cin) | (y & cin), x ^ y ^ cin};
    endfunction

    // Output selector shared by every slice.
    function automatic logic pick(input alu_sel_e sel, input logic x, input logic y,
                                  input logic sum, input logic less);
        logic r;
        unique case (sel)
            SEL_AND:  r = x & y;
            SEL_OR:   r = x | y;
            SEL_SUM:  r = sum;
            default:  r = less;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    input  alu_ctrl_t ctrl_i,
    input  logic      carry_i,
    input  logic      less_i,
    output logic      res_o,
    output logic      carry_o
);
    logic       x_d;
    logic       y_d;
    logic [1:0] add_d;

    always_comb begin
        x_d     = a_i ^ ctrl_i.inv_a;
        y_d     = b_i ^ ctrl_i.neg_b;
        add_d   = full_add(x_d, y_d, carry_i);
        carry_o = add_d[1];
        res_o   = pick(ctrl_i.sel, x_d, y_d, add_d[0], less_i);
    end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    input  alu_ctrl_t ctrl_i,
    input  logic      carry_i,
    output logic      res_o,
    output logic      set_o,
    output logic      ovf_o
);
    logic       x_d;
    logic       y_d;
    logic [1:0] add_d;

    always_comb begin
        x_d   = a_i ^ ctrl_i.inv_a;
        y_d   = b_i ^ ctrl_i.neg_b;
        add_d = full_add(x_d, y_d, carry_i);
        set_o = add_d[0];
        ovf_o = carry_i ^ add_d[1];
        // The top bit never carries the less-than value.
        res_o = pick(ctrl_i.sel, x_d, y_d, add_d[0], 1'b0);
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);
    always_comb zero_o = ~|word_i;
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o
);
    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl_d;
    logic             valid_d;
    logic             arith_d;
    logic [MSB:0]     carry_d;
    logic [MSB:0]     raw_d;
    logic             set_d;
    logic             ovf_d;
    logic             less_d;

    always_comb begin
        ctrl_d  = alu_ctrl_t'(op_i);
        arith_d = (op_i == OP_ADD) || (op_i == OP_SUB);
        valid_d = arith_d || (op_i == OP_AND) || (op_i == OP_OR) ||
                  (op_i == OP_SLT) || (op_i == OP_NOR);
        carry_d[0] = ctrl_d.neg_b;
        less_d  = set_d ^ ovf_d;
    end

    for (genvar i = 0; i < MSB; i++) begin : g_slice
        alu_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .ctrl_i  (ctrl_d),
            .carry_i (carry_d[i]),
            .less_i  ((i == 0) ? less_d : 1'b0),
            .res_o   (raw_d[i]),
            .carry_o (carry_d[i+1])
        );
    end

    alu_msb_slice u_msb (
        .a_i     (a_i[MSB]),
        .b_i     (b_i[MSB]),
        .ctrl_i  (ctrl_d),
        .carry_i (carry_d[MSB]),
        .res_o   (raw_d[MSB]),
        .set_o   (set_d),
        .ovf_o   (ovf_d)
    );

    always_comb begin
        result_o   = valid_d ? raw_d : '0;
        overflow_o = arith_d & ovf_d;
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i (result_o),
        .zero_o (zero_o)
    );

    always_comb begin
        if (!$isunknown({a_i, b_i, op_i})) begin
            if (op_i == OP_ADD)
                assert_add_matches_R2: assert (result_o == a_i + b_i);
            if (op_i == OP_SUB)
                assert_sub_matches_R3: assert (result_o == a_i - b_i);
            if (op_i == OP_SLT) begin
                assert_slt_signed_R4: assert (result_o[0] == ($signed(a_i) < $signed(b_i)));
                assert_slt_upper_clear_R4: assert (result_o[MSB:1] == '0);
            end
            if (op_i == OP_NOR)
                assert_nor_matches_R5: assert (result_o == ~(a_i | b_i));
            assert_ovf_only_arith_R7: assert (!overflow_o || arith_d);
            if (!valid_d)
                assert_unused_zero_R8: assert (result_o == '0 && zero_o);
        end
    end
endmodule

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 5;
    localparam int WW         = 32;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NW-1:0] a_n, b_n, r_n;
    logic [WW-1:0] a_w, b_w, r_w;
    logic [3:0]    op_n, op_w;
    logic          z_n, v_n, z_w, v_w;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    bitslice_alu #(.WIDTH(NW)) u_bitslice_alu (
        .a_i(a_n), .b_i(b_n), .op_i(op_n),
        .result_o(r_n), .zero_o(z_n), .overflow_o(v_n)
    );

    bitslice_alu #(.WIDTH(WW)) u_bitslice_alu_wide (
        .a_i(a_w), .b_i(b_w), .op_i(op_w),
        .result_o(r_w), .zero_o(z_w), .overflow_o(v_w)
    );

    // Arithmetic reference model for width w (w <= 32).
    function automatic void model(input int w, input logic [3:0] op,
                                  input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic v, output logic z);
        logic [31:0] mask, s, d, ax, bx;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        s  = (a + b) & mask;
        d  = (a - b) & mask;
        ax = a[w-1] ? (a | ~mask) : a;
        bx = b[w-1] ? (b | ~mask) : b;
        v  = 1'b0;
        case (op)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b0010: begin r = s; v = (a[w-1] == b[w-1]) && (s[w-1] != a[w-1]); end
            4'b0110: begin r = d; v = (a[w-1] != b[w-1]) && (d[w-1] != a[w-1]); end
            4'b0111: r = ($signed(ax) < $signed(bx)) ? 32'h1 : 32'h0;
            4'b1100: r = ~(a | b) & mask;
            default: r = 32'h0;
        endcase
        z = (r == 32'h0);
    endfunction

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'b0000, 4'b0001: return "R1";
            4'b0010: return "R2";
            4'b0110: return "R3";
            4'b0111: return "R4";
            4'b1100: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] got_r, input logic got_z, input logic got_v,
                           input int w);
        logic [31:0] er;
        logic ev, ez;
        model(w, op, a, b, er, ev, ez);
        checks++;
        if (got_r !== er) begin
            errors++;
            $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h",
                     tag(op), op, a, b, got_r, er);
        end
        checks++;
        if (got_z !== ez) begin
            errors++;
            $display("FAIL R6 zero op=%b a=%h b=%h actual=%b expected=%b", op, a, b, got_z, ez);
        end
        checks++;
        if (got_v !== ev) begin
            errors++;
            $display("FAIL R7 overflow op=%b a=%h b=%h actual=%b expected=%b", op, a, b, got_v, ev);
        end
    endtask

    task automatic wide(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        op_w = op; a_w = a; b_w = b;
        @(negedge clk);
        compare(op, a, b, r_w, z_w, v_w, WW);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        a_n = '0; b_n = '0; op_n = 4'b0000;
        a_w = '0; b_w = '0; op_w = 4'b0000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // Idle state: AND of zeros gives a zero result, zero flag high (R6).
        compare(4'b0000, 32'h0, 32'h0, {{(32-NW){1'b0}}, r_n}, z_n, v_n, NW);

        // Exhaustive sweep over every code and operand pair, R1..R8.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < (1 << NW); a++) begin
                for (int b = 0; b < (1 << NW); b++) begin
                    @(posedge clk);
                    op_n = 4'(op); a_n = NW'(a); b_n = NW'(b);
                    @(negedge clk);
                    compare(4'(op), 32'(a), 32'(b), {{(32-NW){1'b0}}, r_n}, z_n, v_n, NW);
                end
            end
        end

        // Full-width corners: R2/R7 positive overflow, R3 negative overflow.
        wide(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
        wide(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        wide(4'b0110, 32'h8000_0000, 32'h0000_0001);
        wide(4'b0110, 32'h1234_5678, 32'h1234_5678);
        // R4 with an overflowing difference in both directions.
        wide(4'b0111, 32'h8000_0000, 32'h0000_0001);
        wide(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
        wide(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
        wide(4'b0111, 32'h0000_0005, 32'h0000_0005);
        // R1, R5 bit patterns, R8 unused codes.
        wide(4'b0000, 32'hF0F0_A5A5, 32'hFF00_5A5A);
        wide(4'b0001, 32'hF0F0_A5A5, 32'h0F0F_0000);
        wide(4'b1100, 32'hF0F0_A5A5, 32'h0F0F_0000);
        wide(4'b0011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wide(4'b1111, 32'h8000_0000, 32'h8000_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule